// File: doc/BRIEF.md
# Nibble-Memory Return Stack Controller

This block keeps the return stack of a small 4-bit processor. The stack is not held in its own registers. It sits in the top 64 nibbles of the shared data memory, from $3C0 to $3FF.

- **Push.** A subroutine call or an interrupt entry packs the program counter, the status flag and the carry flag into a 16-bit frame. The block writes that frame as four nibbles on a single-port memory interface, one nibble per clock. The level pointer then advances.
- **Pop.** A return reads the four nibbles of the newest frame back, one per clock. A plain return rebuilds only the program counter. The status and carry flags it outputs are the values present on `st_i`/`ca_i` when the return was requested. A return-from-interrupt restores all three values from memory.

The pointer counts levels modulo 16, so deep nesting silently overwrites the oldest frames. A separate clear input puts the pointer back to level 0 and stops any transfer in progress. The block never touches a stack-region nibble except through the frame it is moving, so unused levels remain ordinary data memory.

Top module: `retstk_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `ram_we_o` and `ram_re_o` are 0 and the level pointer is 0, so the first push lands in addresses $3FF down to $3FC.
- R2: A call (`call_i`) or interrupt (`intr_i`) strobe accepted while idle raises `busy_o` in the next cycle. The block then writes for exactly four cycles, to addresses $3FF−4·L, −4·L−1, −4·L−2 and −4·L−3 in that order, where L is the level pointer before the push. The pointer then increments.
- R3: The frame word is {PC[13:12], ST, CA, PC[11:0]}. Nibble 0 holds bits 15:12, nibble 1 holds bits 11:8, nibble 2 holds bits 7:4 and nibble 3 holds bits 3:0.
- R4: A plain return (`ret_i`) reads the frame of level L−1 in the same address order over four cycles and puts its PC on `pc_o`. `st_o`/`ca_o` take the `st_i`/`ca_i` values sampled with the strobe.
- R5: A return-from-interrupt (`reti_i`) drives `pc_o`, `st_o` and `ca_o` from the frame read back, and decrements the pointer.
- R6: `done_o` pulses for one cycle, in the first idle cycle after the fourth read. `pc_o`/`st_o`/`ca_o` are valid from that cycle and hold until the next completed return.
- R7: Strobes arriving while `busy_o` is high are ignored. When strobes coincide, a push wins over a return-from-interrupt, which wins over a plain return.
- R8: The pointer wraps modulo 16. A 17th push overwrites level 0, and a return at level 0 reads level 15 ($3C3 down to $3C0).
- R9: `ptr_clr_i` forces the pointer to level 0, aborts any transfer without a further write, and beats any strobe in the same cycle.
- R10: Memory writes only reach the four nibbles of the frame being pushed. Every other stack-region nibble keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_clr_i | input | 1 | Clear the level pointer and abort |
| call_i | input | 1 | Subroutine call strobe (push) |
| intr_i | input | 1 | Interrupt entry strobe (push) |
| ret_i | input | 1 | Plain return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | 14 | Program counter to save |
| st_i | input | 1 | Current status flag |
| ca_i | input | 1 | Current carry flag |
| pc_o | output | 14 | Restored program counter |
| st_o | output | 1 | Status flag after return |
| ca_o | output | 1 | Carry flag after return |
| done_o | output | 1 | One-cycle return-complete pulse |
| busy_o | output | 1 | Frame transfer in progress |
| ram_addr_o | output | 10 | Nibble memory address |
| ram_we_o | output | 1 | Nibble write enable |
| ram_re_o | output | 1 | Nibble read enable |
| ram_wdata_o | output | 4 | Nibble write data |
| ram_rdata_i | input | 4 | Nibble read data, valid in the cycle the address is driven |

## Verification
The hardest state to reach is pointer wrap-around. Level 0 must be overwritten by a seventeenth push, and a return from an empty stack must fetch the frame at level 15. Both need a long, ordered run of frames whose contents can be told apart. The bench clears the pointer and pushes seventeen frames, each with its own PC and alternating status flag. It then pops with return-from-interrupt and checks that the newest frame came back from level 0. Next it clears again and pops once, so the read wraps below zero onto the frame left at level 15. A clear that arrives in the middle of a push is also driven, at a cycle chosen relative to `busy_o`.

// File: rtl/retstk_pkg.sv
package retstk_pkg;

  localparam int PC_W   = 14;
  localparam int NIB_W  = 4;
  localparam int NIBS   = 4;
  localparam int IDX_W  = $clog2(NIBS);
  localparam int WORD_W = NIB_W * NIBS;
  localparam int ACC_W  = WORD_W - NIB_W;
  localparam int ADDR_W = 10;

  typedef enum logic [1:0] {OP_NONE, OP_PUSH, OP_RET, OP_RETI} op_e;
  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP} seq_e;

  // frame word: {pc[13:12], st, ca, pc[11:0]}
  function automatic logic [WORD_W-1:0] pack_frame(input logic [PC_W-1:0] pc,
                                                   input logic st, input logic ca);
    return {pc[PC_W-1 -: 2], st, ca, pc[PC_W-3:0]};
  endfunction

  function automatic logic [PC_W-1:0] unpack_pc(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1 -: 2], w[PC_W-3:0]};
  endfunction

  function automatic logic unpack_st(input logic [WORD_W-1:0] w);
    return w[PC_W-1];
  endfunction

  function automatic logic unpack_ca(input logic [WORD_W-1:0] w);
    return w[PC_W-2];
  endfunction

  // nibble k counted from the most significant end
  function automatic logic [NIB_W-1:0] nib_of(input logic [WORD_W-1:0] w,
                                              input int unsigned k);
    return NIB_W'(w >> (NIB_W * (NIBS - 1 - k)));
  endfunction

  // stack grows downward from top; frame of level lvl, nibble k
  function automatic logic [ADDR_W-1:0] nib_addr(input logic [ADDR_W-1:0] top,
                                                input int unsigned lvl,
                                                input int unsigned k);
    return top - ADDR_W'(lvl * NIBS + k);
  endfunction

endpackage

// File: rtl/retstk_arb.sv
module retstk_arb
  import retstk_pkg::*;
(
  input  logic busy,
  input  logic clr,
  input  logic call_i,
  input  logic intr_i,
  input  logic ret_i,
  input  logic reti_i,
  output op_e  op
);
  always_comb begin
    op = OP_NONE;
    if (!busy && !clr) begin
      if (intr_i || call_i) op = OP_PUSH;
      else if (reti_i)      op = OP_RETI;
      else if (ret_i)       op = OP_RET;
    end
  end
endmodule

// File: rtl/retstk_seq.sv
module retstk_seq
  import retstk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  op_e              op,
  output logic             busy,
  output logic             push_act,
  output logic             pop_act,
  output logic             reti_q,
  output logic [IDX_W-1:0] idx,
  output logic             last,
  output logic             push_fin,
  output logic             pop_fin
);
  seq_e state;

  assign busy     = (state != S_IDLE);
  assign push_act = (state == S_PUSH);
  assign pop_act  = (state == S_POP);
  assign last     = (idx == IDX_W'(NIBS - 1));
  assign push_fin = push_act && last && !clr;
  assign pop_fin  = pop_act && last && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      reti_q <= 1'b0;
    end else if (clr) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          idx <= '0;
          case (op)
            OP_PUSH: state <= S_PUSH;
            OP_RET:  begin state <= S_POP; reti_q <= 1'b0; end
            OP_RETI: begin state <= S_POP; reti_q <= 1'b1; end
            default: state <= S_IDLE;
          endcase
        end
        default: begin
          if (last) begin
            state <= S_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/retstk_ptr.sv
module retstk_ptr #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [LVL_W-1:0] level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   level <= '0;
    else if (clr) level <= '0;
    else if (inc) level <= level + LVL_W'(1);
    else if (dec) level <= level - LVL_W'(1);
  end
endmodule

// File: rtl/retstk_frame.sv
module retstk_frame
  import retstk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             st_i,
  input  logic             ca_i,
  input  logic [IDX_W-1:0] idx,
  input  logic             pop_act,
  input  logic             last,
  input  logic             pop_fin,
  input  logic             reti_q,
  input  logic [NIB_W-1:0] rdata,
  output logic [NIB_W-1:0] wdata,
  output logic [PC_W-1:0]  pc_o,
  output logic             st_o,
  output logic             ca_o,
  output logic             done_o
);
  logic [WORD_W-1:0] wr_word;
  logic [ACC_W-1:0]  acc;
  logic              keep_st, keep_ca;
  logic [WORD_W-1:0] rd_word;

  assign wdata   = nib_of(wr_word, 32'(idx));
  assign rd_word = {acc, rdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_word <= '0;
      acc     <= '0;
      keep_st <= 1'b0;
      keep_ca <= 1'b0;
      pc_o    <= '0;
      st_o    <= 1'b0;
      ca_o    <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= pop_fin;
      if (op == OP_PUSH) wr_word <= pack_frame(pc_i, st_i, ca_i);
      if (op == OP_RET || op == OP_RETI) begin
        keep_st <= st_i;
        keep_ca <= ca_i;
      end
      if (pop_act && !last) acc <= {acc[ACC_W-NIB_W-1:0], rdata};
      if (pop_fin) begin
        pc_o <= unpack_pc(rd_word);
        st_o <= reti_q ? unpack_st(rd_word) : keep_st;
        ca_o <= reti_q ? unpack_ca(rd_word) : keep_ca;
      end
    end
  end
endmodule

// File: rtl/retstk_ctrl.sv
module retstk_ctrl
  import retstk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STACK_TOP = 10'h3FF,
  parameter int                LEVELS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_clr_i,
  input  logic              call_i,
  input  logic              intr_i,
  input  logic              ret_i,
  input  logic              reti_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              st_i,
  input  logic              ca_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              st_o,
  output logic              ca_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [NIB_W-1:0]  ram_wdata_o,
  input  logic [NIB_W-1:0]  ram_rdata_i
);
  localparam int LVL_W = $clog2(LEVELS);

  op_e              op;
  logic             busy, push_act, pop_act, reti_q, last;
  logic             push_fin, pop_fin;
  logic [IDX_W-1:0] idx;
  logic [LVL_W-1:0] level, lvl_sel;
  logic             push_go;

  assign push_go = (op == OP_PUSH);

  retstk_arb u_arb (
    .busy(busy), .clr(ptr_clr_i), .call_i(call_i), .intr_i(intr_i),
    .ret_i(ret_i), .reti_i(reti_i), .op(op)
  );

  retstk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr_i), .op(op), .busy(busy),
    .push_act(push_act), .pop_act(pop_act), .reti_q(reti_q), .idx(idx),
    .last(last), .push_fin(push_fin), .pop_fin(pop_fin)
  );

  retstk_ptr #(.LVL_W(LVL_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr_i), .inc(push_fin),
    .dec(pop_fin), .level(level)
  );

  retstk_frame u_frame (
    .clk(clk), .rst_n(rst_n), .op(op), .pc_i(pc_i), .st_i(st_i), .ca_i(ca_i),
    .idx(idx), .pop_act(pop_act), .last(last), .pop_fin(pop_fin),
    .reti_q(reti_q), .rdata(ram_rdata_i), .wdata(ram_wdata_o),
    .pc_o(pc_o), .st_o(st_o), .ca_o(ca_o), .done_o(done_o)
  );

  // push uses the current level, pop the one below it (modulo LEVELS)
  assign lvl_sel    = push_act ? level : level - LVL_W'(1);
  assign ram_addr_o = nib_addr(STACK_TOP, 32'(lvl_sel), 32'(idx));
  assign ram_we_o   = push_act && !ptr_clr_i;
  assign ram_re_o   = pop_act && !ptr_clr_i;
  assign busy_o     = busy;

endmodule

// File: rtl/retstk_chk.sv
module retstk_chk #(
  parameter int                AW     = 10,
  parameter int                LW     = 4,
  parameter logic [AW-1:0]     TOP    = 10'h3FF,
  parameter logic [AW-1:0]     BASE   = 10'h3C0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_clr_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ram_we_o,
  input logic          ram_re_o,
  input logic [AW-1:0] ram_addr_o,
  input logic          push_go,
  input logic          push_fin,
  input logic [LW-1:0] level
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ram_we_o && !ram_re_o));

  a_r2_push_starts: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> (ram_we_o || ptr_clr_i));

  a_r2_addr_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && $past(ram_we_o)) |-> (ram_addr_o == $past(ram_addr_o) - AW'(1)));

  a_r6_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ram_re_o));

  a_r7_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we_o, ram_re_o}));

  a_r8_level_advance: assert property (@(posedge clk) disable iff (!rst_n)
    push_fin |=> (level == $past(level) + LW'(1)));

  a_r9_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr_i |=> (!busy_o && level == '0));

  a_r10_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o || ram_re_o) |-> (ram_addr_o >= BASE && ram_addr_o <= TOP));
endmodule

bind retstk_ctrl retstk_chk #(
  .AW(retstk_pkg::ADDR_W), .LW(LVL_W), .TOP(STACK_TOP),
  .BASE(STACK_TOP - retstk_pkg::ADDR_W'(LEVELS * retstk_pkg::NIBS - 1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .ptr_clr_i(ptr_clr_i), .busy_o(busy_o),
  .done_o(done_o), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o),
  .ram_addr_o(ram_addr_o), .push_go(push_go), .push_fin(push_fin),
  .level(level)
);

// File: tb/retstk_ctrl_tb.sv
module retstk_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_clr_i = 0, call_i = 0, intr_i = 0, ret_i = 0, reti_i = 0;
  logic [13:0] pc_i = '0;
  logic        st_i = 0, ca_i = 0;
  logic [13:0] pc_o;
  logic        st_o, ca_o, done_o, busy_o, ram_we, ram_re;
  logic [9:0]  ram_addr;
  logic [3:0]  ram_wdata, ram_rdata;

  logic [3:0]  mem [0:1023];
  int n_tests = 0, n_fail = 0, re_cnt = 0, we_cnt = 0;
  logic [13:0] res_pc;
  logic        res_st, res_ca, res_done;
  int          res_cyc;

  always #2.5 clk = ~clk;

  retstk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ptr_clr_i(ptr_clr_i), .call_i(call_i),
    .intr_i(intr_i), .ret_i(ret_i), .reti_i(reti_i), .pc_i(pc_i),
    .st_i(st_i), .ca_i(ca_i), .pc_o(pc_o), .st_o(st_o), .ca_o(ca_o),
    .done_o(done_o), .busy_o(busy_o), .ram_addr_o(ram_addr),
    .ram_we_o(ram_we), .ram_re_o(ram_re), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) begin
    if (ram_we) begin mem[ram_addr] <= ram_wdata; we_cnt <= we_cnt + 1; end
    if (ram_re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 call, 1 interrupt, 2 return, 3 return-from-interrupt
  task automatic run_op(input int kind, input logic [13:0] pc, input logic st, input logic ca);
    @(negedge clk);
    pc_i = pc; st_i = st; ca_i = ca;
    case (kind)
      0: call_i = 1; 1: intr_i = 1; 2: ret_i = 1; default: reti_i = 1;
    endcase
    @(negedge clk);
    call_i = 0; intr_i = 0; ret_i = 0; reti_i = 0;
    st_i = ~st; ca_i = ~ca;   // later changes must not matter
    res_cyc = 0;
    while (busy_o && res_cyc < 20) begin @(negedge clk); res_cyc++; end
    res_pc = pc_o; res_st = st_o; res_ca = ca_o; res_done = done_o;
  endtask

  // {kind[1:0], pc[13:0], st, ca, exp_pc[13:0], exp_st, exp_ca}
  localparam logic [33:0] VEC [6] = '{
    {2'd0, 14'h1234, 1'b1, 1'b0, 14'h0000, 1'b0, 1'b0},
    {2'd1, 14'h2ABC, 1'b0, 1'b1, 14'h0000, 1'b0, 1'b0},
    {2'd0, 14'h3FFF, 1'b1, 1'b1, 14'h0000, 1'b0, 1'b0},
    {2'd3, 14'h0000, 1'b0, 1'b0, 14'h3FFF, 1'b1, 1'b1},
    {2'd2, 14'h0000, 1'b1, 1'b0, 14'h2ABC, 1'b1, 1'b0},
    {2'd3, 14'h0000, 1'b0, 1'b0, 14'h1234, 1'b1, 1'b0}
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int rc, wc;
    for (int a = 0; a < 1024; a++) mem[a] = 4'(a ^ 5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 mem access", 32'({ram_we, ram_re}), 0);

    // R3 frame layout at level 0: 0x2D5A st1 ca0 -> A D 5 A
    run_op(0, 14'h2D5A, 1'b1, 1'b0);
    chk("R2 push cycles", 32'(res_cyc), 4);
    chk("R3 nibble0 at 3FF", 32'(mem[10'h3FF]), 32'hA);
    chk("R3 nibble1 at 3FE", 32'(mem[10'h3FE]), 32'hD);
    chk("R3 nibble2 at 3FD", 32'(mem[10'h3FD]), 32'h5);
    chk("R3 nibble3 at 3FC", 32'(mem[10'h3FC]), 32'hA);
    chk("R10 3FB untouched", 32'(mem[10'h3FB]), 32'(4'(10'h3FB ^ 5)));
    run_op(3, 14'h0, 1'b0, 1'b1);
    chk("R5 reti pc", 32'(res_pc), 32'h2D5A);
    chk("R5 reti flags", 32'({res_st, res_ca}), 32'b10);
    chk("R6 done pulse", 32'(res_done), 1);
    @(negedge clk);
    chk("R6 done one cycle", 32'(done_o), 0);
    chk("R6 pc holds", 32'(pc_o), 32'h2D5A);

    // vector table: nested calls and mixed returns
    for (int i = 0; i < 6; i++) begin
      logic [33:0] v;
      v = VEC[i];
      run_op(int'(v[33:32]), v[31:18], v[17], v[16]);
      chk("R2 transfer cycles", 32'(res_cyc), 4);
      if (v[33:32] >= 2) begin
        chk(v[33:32] == 3 ? "R5 reti pc" : "R4 ret pc", 32'(res_pc), 32'(v[15:2]));
        chk(v[33:32] == 3 ? "R5 reti flags" : "R4 ret keeps flags",
            32'({res_st, res_ca}), 32'(v[1:0]));
        chk("R6 done", 32'(res_done), 1);
      end else begin
        chk("R6 no done on push", 32'(res_done), 0);
      end
    end

    // R7: strobe during busy ignored; push beats pop when simultaneous
    rc = re_cnt; wc = we_cnt;
    @(negedge clk); pc_i = 14'h0111; st_i = 0; ca_i = 0; call_i = 1;
    @(negedge clk); call_i = 0; reti_i = 1;
    @(negedge clk); reti_i = 0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk("R7 strobe while busy ignored", 32'(busy_o), 0);
    chk("R7 no read issued", 32'(re_cnt - rc), 0);
    @(negedge clk); pc_i = 14'h0222; call_i = 1; ret_i = 1;
    @(negedge clk); call_i = 0; ret_i = 0;
    while (busy_o) @(negedge clk);
    chk("R7 push wins, writes", 32'(we_cnt - wc), 8);
    chk("R7 push wins, no reads", 32'(re_cnt - rc), 0);
    run_op(2, 14'h0, 1'b0, 1'b0);
    chk("R4 ret pc after priority", 32'(res_pc), 32'h0222);
    run_op(2, 14'h0, 1'b0, 1'b0);
    chk("R4 ret pc second", 32'(res_pc), 32'h0111);

    // R9: clear sets level 0
    run_op(0, 14'h0AAA, 1'b0, 1'b0);
    run_op(0, 14'h0BBB, 1'b0, 1'b0);
    @(negedge clk); ptr_clr_i = 1; call_i = 1;
    @(negedge clk); ptr_clr_i = 0; call_i = 0;
    chk("R9 clear beats strobe", 32'(busy_o), 0);
    run_op(0, 14'h0CCC, 1'b0, 1'b0);
    chk("R9 push lands at 3FD", 32'(mem[10'h3FD]), 32'hC);
    chk("R10 level1 frame untouched", 32'(mem[10'h3FA]), 32'hB);
    run_op(2, 14'h0, 1'b0, 1'b0);
    chk("R9 return after clear", 32'(res_pc), 32'h0CCC);
    // clear in the middle of a push
    wc = we_cnt;
    @(negedge clk); pc_i = 14'h0DDD; call_i = 1;
    @(negedge clk); call_i = 0;
    @(negedge clk); ptr_clr_i = 1;
    @(negedge clk); ptr_clr_i = 0;
    chk("R9 abort idles", 32'(busy_o), 0);
    chk("R9 abort write count", 32'(we_cnt - wc), 1);

    // R8 wrap: 17 pushes, then pops
    @(negedge clk); ptr_clr_i = 1;
    @(negedge clk); ptr_clr_i = 0;
    for (int i = 0; i < 17; i++) run_op(0, 14'(14'h100 + i), 1'(i), 1'b0);
    run_op(3, 14'h0, 1'b0, 1'b1);
    chk("R8 17th push overwrote level 0", 32'(res_pc), 32'h0110);
    chk("R8 17th flags", 32'({res_st, res_ca}), 32'b00);
    run_op(3, 14'h0, 1'b0, 1'b1);
    chk("R8 next level down", 32'(res_pc), 32'h010F);
    @(negedge clk); ptr_clr_i = 1;
    @(negedge clk); ptr_clr_i = 0;
    run_op(3, 14'h0, 1'b0, 1'b1);
    chk("R8 empty pop reads level 15", 32'(res_pc), 32'h010F);
    chk("R8 empty pop flags", 32'({res_st, res_ca}), 32'b10);

    summary();
    $finish;
  end
endmodule